// File: doc/BRIEF.md
# Addressed Serial Host Register Port

This block is a serial slave port. Through it, a host microcontroller reads and writes a bank of registers inside the chip. The host pulls chip select low and clocks in one address byte. It then clocks any number of data bytes in the same window. Bit 7 of the address byte selects the space. When the bit is clear, the data bytes go into a write-only register. When the bit is set, the data bytes come out of a read-only register. Every byte of a burst uses the same register address, so a 16-bit register is moved as two bytes, high byte first.

The serial side uses SPI mode 0 signalling with bytes sent MSB first. The block samples the host data on the rising serial clock and changes reply data on the falling serial clock. All serial pins are double-flop synchronised into the system clock, which must run at least four times faster than the serial clock. Toward the core, each completed write byte produces a one-cycle strobe carrying the address and data. The core answers reads through a combinational data input and moves to its next byte on a consume strobe.

The block also holds two registers of its own:
- A status register, which latches event pulses from the core. It sits at read address 0x80.
- An interrupt mask register, which is written at address 0x00.

The active-low interrupt output is asserted while any latched status bit is also enabled in the mask. A completed read of the status byte clears the bits it returned.

Top module: `hostreg_serial_port`

States of the frame controller:
- ST_IDLE: chip select is inactive.
- ST_ADDR: the address byte is being shifted in.
- ST_WDATA: write data bytes are being received.
- ST_RDATA: read data bytes are being sent.

Transitions:
- ST_IDLE goes to ST_ADDR when the synchronised chip select becomes active.
- ST_ADDR goes to ST_WDATA on the eighth address bit when bit 7 of the address is 0.
- ST_ADDR goes to ST_RDATA on the eighth address bit when bit 7 of the address is 1.
- Every state returns to ST_IDLE as soon as the synchronised chip select goes inactive.

## Requirements
- R1: After reset, irq_n is 1, miso_oe is 0, miso is 0, and neither wr_stb nor rd_stb is asserted.
- R2: When the address byte has bit 7 = 0, each completed 8-bit data byte (MSB first) gives exactly one single-cycle wr_stb. On that strobe, wr_addr equals the low 7 address bits and wr_data equals the byte.
- R3: In a multi-byte write burst, every byte is strobed to the same wr_addr, in the order the bytes were sent.
- R4: When the address byte has bit 7 = 1 (and the address is not 0x80), rd_addr shows the low 7 address bits and each data byte returns rd_data MSB first on miso. miso only changes after a falling serial clock edge, so it is stable while the serial clock is high. One rd_stb marks each completed byte.
- R5: A transaction that carries only the address byte produces no wr_stb.
- R6: If chip select rises partway through a byte, that byte is discarded with no strobe, and the next transaction starts again with an address byte.
- R7: miso_oe is 1 only during a transaction. While chip select is high, miso_oe is 0 and miso is 0.
- R8: A 1 on a bit of status_evt sets the matching status bit. irq_n is 0 exactly when a set status bit is enabled in the mask register. The mask register is loaded from data written to address 0x00.
- R9: A read at address 0x80 returns the latched status. Completing that byte clears the returned bits, so irq_n returns to 1. No rd_stb is issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial reply data to host |
| miso_oe | output | 1 | Reply driver enable |
| irq_n | output | 1 | Active-low interrupt |
| wr_stb | output | 1 | One-cycle write strobe to core |
| wr_addr | output | 7 | Write register address |
| wr_data | output | 8 | Write data byte |
| rd_addr | output | 7 | Read register address |
| rd_data | input | 8 | Read data byte supplied by core |
| rd_stb | output | 1 | Read byte consumed strobe |
| status_evt | input | 8 | Status event pulses from core |

## Verification
A raw serial clock edge is seen inside the block two synchroniser stages and one edge flop later. wr_stb and rd_stb therefore appear about four system cycles after the eighth rising edge. The reply bit settles about four cycles after a falling edge. The bench holds each serial clock half period for eight system cycles. It samples miso at the end of the low half and again twice during the high half. It looks at the strobe logs and interrupt pin only after chip select has risen and several further half periods have passed, so every result is due well before it is compared. Expected bytes are worked out arithmetically from the address and the byte index. Expected interrupt states come from the mask and event values the bench applied.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } hsp_state_e;
endpackage

// File: rtl/hsp_sync_edge.sv
module hsp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    input  logic cs_n_raw,
    input  logic mosi_raw,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);
    localparam int NS = (STAGES < 2) ? 2 : STAGES;
    // bit order {sclk, cs_n, mosi}; idle level has chip select high
    localparam logic [2:0] IDLE_V = 3'b010;

    logic [2:0] chain [NS];
    logic       sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) chain[i] <= IDLE_V;
            sclk_prev <= 1'b0;
        end else begin
            chain[0] <= {sclk_raw, cs_n_raw, mosi_raw};
            for (int i = 1; i < NS; i++) chain[i] <= chain[i-1];
            sclk_prev <= chain[NS-1][2];
        end
    end

    assign sclk_rise = chain[NS-1][2] & ~sclk_prev;
    assign sclk_fall = ~chain[NS-1][2] & sclk_prev;
    assign cs_act    = ~chain[NS-1][1];
    assign mosi_s    = chain[NS-1][0];
endmodule

// File: rtl/hsp_frame_fsm.sv
module hsp_frame_fsm
    import hsp_pkg::*;
#(
    parameter int DW         = 8,
    parameter int STATUS_IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          cs_act,
    input  logic          mosi_s,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] status_val,
    output logic          wr_stb,
    output logic [DW-2:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [DW-2:0] rd_addr,
    output logic          rd_stb,
    output logic          stat_clr,
    output logic [DW-1:0] stat_snap,
    output logic          miso,
    output logic          miso_oe
);
    localparam int AW = DW - 1;
    localparam int CW = $clog2(DW);

    hsp_state_e    state, state_nx;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] rx_sh, addr_q, tx_sh, wdat_q, snap_q;
    logic          load_pend;
    logic          byte_done, is_status;
    logic [DW-1:0] rx_byte;

    assign rx_byte   = {rx_sh[DW-2:0], mosi_s};
    assign byte_done = sclk_rise && (bit_cnt == CW'(DW-1));
    assign is_status = addr_q[DW-1] && (addr_q[AW-1:0] == AW'(STATUS_IDX));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_act) state_nx = ST_ADDR;
            ST_ADDR: begin
                if (!cs_act)        state_nx = ST_IDLE;
                else if (byte_done) state_nx = rx_byte[DW-1] ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA: if (!cs_act) state_nx = ST_IDLE;
            ST_RDATA: if (!cs_act) state_nx = ST_IDLE;
        endcase
    end

    // datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            addr_q    <= '0;
            tx_sh     <= '0;
            wdat_q    <= '0;
            snap_q    <= '0;
            load_pend <= 1'b0;
            wr_stb    <= 1'b0;
            rd_stb    <= 1'b0;
            stat_clr  <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            stat_clr <= 1'b0;
            if (!cs_act || state == ST_IDLE) begin
                bit_cnt   <= '0;
                load_pend <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    rx_sh   <= rx_byte;
                    bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
                    if (byte_done) begin
                        case (state)
                            ST_ADDR: begin
                                addr_q    <= rx_byte;
                                load_pend <= rx_byte[DW-1];
                            end
                            ST_WDATA: begin
                                wr_stb <= 1'b1;
                                wdat_q <= rx_byte;
                            end
                            ST_RDATA: begin
                                load_pend <= 1'b1;
                                rd_stb    <= !is_status;
                                stat_clr  <= is_status;
                            end
                            default: ;
                        endcase
                    end
                end
                if (sclk_fall && state == ST_RDATA) begin
                    if (load_pend) begin
                        load_pend <= 1'b0;
                        tx_sh     <= is_status ? status_val : rd_data;
                        if (is_status) snap_q <= status_val;
                    end else begin
                        tx_sh <= {tx_sh[DW-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign wr_addr   = addr_q[AW-1:0];
    assign rd_addr   = addr_q[AW-1:0];
    assign wr_data   = wdat_q;
    assign stat_snap = snap_q;
    assign miso      = (state == ST_RDATA) ? tx_sh[DW-1] : 1'b0;
    assign miso_oe   = (state != ST_IDLE);

    AST_WR_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R2
    AST_RD_STB_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $past(state) == ST_RDATA); // R4
    AST_NO_STB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> (!wr_stb && !rd_stb)); // R6
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_oe); // R7
endmodule

// File: rtl/hsp_status_unit.sv
module hsp_status_unit #(
    parameter int DW        = 8,
    parameter int MASK_ADDR = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt,
    input  logic          wr_stb,
    input  logic [DW-2:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          clr,
    input  logic [DW-1:0] snap,
    output logic [DW-1:0] status_q,
    output logic          irq_n
);
    localparam int AW = DW - 1;

    logic [DW-1:0] mask_q, stat_nx, mask_nx;
    logic          mask_wr;

    assign mask_wr = wr_stb && (wr_addr == AW'(MASK_ADDR));

    always_comb begin
        stat_nx = (status_q & ~(clr ? snap : '0)) | evt;
        mask_nx = mask_wr ? wr_data : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
            irq_n    <= 1'b1;
        end else begin
            status_q <= stat_nx;
            mask_q   <= mask_nx;
            irq_n    <= ~|(stat_nx & mask_nx);
        end
    end

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(|evt) || $past(mask_wr))); // R8
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && evt == '0) |=> $stable(status_q)); // R8
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0) |=> ((status_q & $past(snap)) == '0)); // R9
endmodule

// File: rtl/hostreg_serial_port.sv
module hostreg_serial_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int STATUS_IDX  = 0,
    parameter int MASK_ADDR   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic              irq_n,
    output logic              wr_stb,
    output logic [DATA_W-2:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-2:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_stb,
    input  logic [DATA_W-1:0] status_evt
);
    logic              s_rise, s_fall, s_cs, s_mosi;
    logic              clr;
    logic [DATA_W-1:0] snap, status_val;

    hsp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_raw(sclk), .cs_n_raw(cs_n), .mosi_raw(mosi),
        .sclk_rise(s_rise), .sclk_fall(s_fall), .cs_act(s_cs), .mosi_s(s_mosi)
    );

    hsp_frame_fsm #(.DW(DATA_W), .STATUS_IDX(STATUS_IDX)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(s_rise), .sclk_fall(s_fall), .cs_act(s_cs), .mosi_s(s_mosi),
        .rd_data(rd_data), .status_val(status_val),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_stb(rd_stb),
        .stat_clr(clr), .stat_snap(snap),
        .miso(miso), .miso_oe(miso_oe)
    );

    hsp_status_unit #(.DW(DATA_W), .MASK_ADDR(MASK_ADDR)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .evt(status_evt),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr(clr), .snap(snap),
        .status_q(status_val), .irq_n(irq_n)
    );
endmodule

// File: tb/hostreg_serial_port_test.sv
module hostreg_serial_port_test;
    localparam int HALF = 8;
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, irq_n, wr_stb, rd_stb;
    logic [6:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic [7:0] status_evt = 8'h00;
    logic [7:0] seq = 8'h00;

    int checks = 0, fails = 0;
    bit done = 0;
    int wn = 0, rn = 0;
    logic [6:0] wa_log [16];
    logic [7:0] wd_log [16];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    bit stab_ok;
    bit oe_seen;

    always #10 clk = ~clk;

    hostreg_serial_port uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .irq_n(irq_n),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_stb(rd_stb),
        .status_evt(status_evt)
    );

    // core model: byte value depends on address and consumed-byte index
    assign rd_data = {rd_addr, 1'b1} ^ seq;

    always @(posedge clk) begin
        if (wr_stb) begin
            if (wn < 16) begin
                wa_log[wn] = wr_addr;
                wd_log[wn] = wr_data;
            end
            wn = wn + 1;
        end
        if (rd_stb) rn = rn + 1;
        if (cs_n) seq <= 8'h00;
        else if (rd_stb) seq <= seq + 8'h01;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_bit(input bit b, input bit rd_phase, output bit r);
        mosi = b;
        wait_clk(HALF);
        r = miso;
        if (miso_oe) oe_seen = 1;
        sclk = 1'b1;
        wait_clk(HALF / 2);
        if (rd_phase && miso !== r) stab_ok = 0;
        wait_clk(HALF - HALF / 2);
        if (rd_phase && miso !== r) stab_ok = 0;
        sclk = 1'b0;
    endtask

    // n data bytes; if cut > 0 the last byte is cut after that many bits
    task automatic xfer(input logic [7:0] a, input int n, input int cut);
        bit r;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int j = 0; j < 8; j++) do_bit(a[7-j], 1'b0, r);
        for (int k = 0; k < n; k++) begin
            int nb;
            nb = (k == n - 1 && cut > 0) ? cut : 8;
            for (int j = 0; j < nb; j++) begin
                do_bit(wbuf[k][7-j], a[7], r);
                rbuf[k][7-j] = r;
            end
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(3 * HALF);
    endtask

    task automatic pulse_evt(input logic [7:0] v);
        @(negedge clk) status_evt = v;
        @(negedge clk) status_evt = 8'h00;
        wait_clk(4);
    endtask

    task automatic write_mask(input logic [7:0] m);
        wbuf[0] = m;
        xfer(8'h00, 1, 0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset state
        chk(irq_n === 1'b1, "R1 irq_n", irq_n, 1);
        chk(miso_oe === 1'b0, "R1 miso_oe", miso_oe, 0);
        chk(miso === 1'b0, "R1 miso", miso, 0);
        chk(wr_stb === 1'b0 && rd_stb === 1'b0, "R1 strobes", {wr_stb, rd_stb}, 0);

        // R2 single-byte write sweep over the write space
        for (int a = 1; a < 128; a += 9) begin
            wn = 0;
            wbuf[0] = 8'((a * 5 + 3) & 255);
            xfer(8'(a), 1, 0);
            chk(wn == 1, "R2 strobe count", wn, 1);
            chk(wa_log[0] == 7'(a), "R2 wr_addr", wa_log[0], a);
            chk(wd_log[0] == 8'((a * 5 + 3) & 255), "R2 wr_data", wd_log[0], (a * 5 + 3) & 255);
        end

        // R3 burst write
        wn = 0;
        for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'hA0 + k * 17);
        xfer(8'h33, 4, 0);
        chk(wn == 4, "R3 burst count", wn, 4);
        for (int k = 0; k < 4; k++) begin
            chk(wa_log[k] == 7'h33, "R3 burst addr", wa_log[k], 8'h33);
            chk(wd_log[k] == 8'(8'hA0 + k * 17), "R3 burst data", wd_log[k], 8'hA0 + k * 17);
        end

        // R5 address-only transaction
        wn = 0;
        xfer(8'h22, 0, 0);
        chk(wn == 0, "R5 address only", wn, 0);

        // R6 abort mid-byte, then a clean write
        for (int cut = 1; cut < 8; cut += 3) begin
            wn = 0;
            wbuf[0] = 8'h5A;
            xfer(8'h44, 1, cut);
            chk(wn == 0, "R6 partial byte dropped", wn, 0);
            wbuf[0] = 8'hC3;
            xfer(8'h45, 1, 0);
            chk(wn == 1 && wa_log[0] == 7'h45 && wd_log[0] == 8'hC3, "R6 restart",
                {wa_log[0], wd_log[0]}, {7'h45, 8'hC3});
        end

        // R4 read sweep with bursts; R7 enable during transfer
        for (int a = 129; a < 256; a += 13) begin
            rn = 0;
            stab_ok = 1;
            oe_seen = 0;
            for (int k = 0; k < 3; k++) wbuf[k] = 8'h00;
            xfer(8'(a), 3, 0);
            for (int k = 0; k < 3; k++)
                chk(rbuf[k] == ({7'(a), 1'b1} ^ 8'(k)), "R4 read byte", rbuf[k],
                    {7'(a), 1'b1} ^ 8'(k));
            chk(rn == 3, "R4 rd_stb count", rn, 3);
            chk(stab_ok, "R4 miso stable while sclk high", stab_ok, 1);
            chk(oe_seen, "R7 miso_oe during transfer", oe_seen, 1);
            chk(miso_oe === 1'b0 && miso === 1'b0, "R7 idle output", {miso_oe, miso}, 0);
        end

        // R8 / R9 status and mask sweep
        for (int i = 0; i < 8; i++) begin
            logic [7:0] on_b, off_b;
            on_b = 8'(1 << i);
            off_b = 8'(1 << ((i + 1) % 8));
            write_mask(on_b);
            pulse_evt(off_b);
            chk(irq_n === 1'b1, "R8 masked event", irq_n, 1);
            pulse_evt(on_b);
            chk(irq_n === 1'b0, "R8 enabled event", irq_n, 0);
            rn = 0;
            wbuf[0] = 8'h00;
            xfer(8'h80, 1, 0);
            chk(rbuf[0] == (on_b | off_b), "R9 status value", rbuf[0], on_b | off_b);
            chk(irq_n === 1'b1, "R9 irq cleared", irq_n, 1);
            chk(rn == 0, "R9 no rd_stb", rn, 0);
            xfer(8'h80, 1, 0);
            chk(rbuf[0] == 8'h00, "R9 status cleared", rbuf[0], 0);
        end

        // R8 mask enable of an already latched bit
        write_mask(8'h00);
        pulse_evt(8'h10);
        chk(irq_n === 1'b1, "R8 mask zero", irq_n, 1);
        write_mask(8'h10);
        wait_clk(4);
        chk(irq_n === 1'b0, "R8 mask enables latched bit", irq_n, 0);
        xfer(8'h80, 1, 0);
        chk(rbuf[0] == 8'h10 && irq_n === 1'b1, "R9 clear after mask", rbuf[0], 8'h10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule